// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns one 64-bit software-generated interrupt request word, written by a requesting core, into a series of pending-set pulses. Each pulse goes to one target core's interrupt state. A request names a 4-bit interrupt number and selects one of two routing modes. In broadcast mode every core except the requester is a target. In targeted mode a core is a target when its upper affinity levels equal the ones carried in the request and the request's 16-bit level-0 list has the bit for its level-0 affinity set.

The block walks a table of core affinities, one core per clock, in ascending index order. In targeted mode it keeps a working copy of the level-0 list and clears each bit as the matching core is served. The walk ends early as soon as that copy is empty. The block keeps no record of which core raised the interrupt. It only drives the pending-set pulse. At the end of each request it gives a one-cycle done pulse with an "any updated" flag, which the surrounding logic uses to decide whether to wake the cores.

Top module: `sgi_dispatch`

## Requirements
- R1: The request word is decoded as follows: level-0 target list in bits [15:0], affinity level 1 in [23:16], interrupt number in [27:24], affinity level 2 in [39:32], routing-mode bit 40 (1 = broadcast), affinity level 3 in [55:48]. Every pending pulse carries the request's interrupt number on `pend_sgi`.
- R2: A request is accepted on a rising clock edge where `req_valid` is high and `busy` is low. A `req_valid` seen while `busy` is high is ignored and is not held for later.
- R3: In broadcast mode every core except `req_core` gets exactly one pending pulse, and the walk visits all `NUM_CORES` cores.
- R4: Core i's affinity entry is `core_aff_tbl[32*i +: 32]`: level 0 in [7:0], level 1 in [15:8], level 2 in [23:16], level 3 in [31:24]. In targeted mode core i is hit only when levels 1 to 3 equal the request's and the list bit indexed by its level 0 is set. A level 0 of 16 or more never matches.
- R5: Cores are visited in ascending index order, one per clock. Each hit produces a one-cycle `pend_valid` pulse with the core index on `pend_core`. Core k's pulse is registered on the (k+1)-th edge after acceptance.
- R6: In targeted mode each hit clears its bit from the working list. The walk ends on the visit that leaves the list empty, so a request whose last hit is core k finishes after k+1 visits.
- R7: A targeted request that hits no core and whose list never empties finishes after all `NUM_CORES` visits with `done_any` low. A request with an empty list finishes after one visit with no pulse.
- R8: `done` is a one-cycle pulse registered together with the final visit's result, and `busy` falls on the same edge. `done_any` is high with `done` exactly when the request produced at least one pulse.
- R9: After reset the block is idle: `busy`, `pend_valid`, `done` and `done_any` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_word | input | 64 | Request word (R1 layout) |
| req_core | input | IDX_W | Index of the requesting core |
| core_aff_tbl | input | NUM_CORES*32 | Affinity entry per core (R4 layout) |
| busy | output | 1 | Walk in progress |
| pend_valid | output | 1 | Pending-set pulse |
| pend_core | output | IDX_W | Core receiving the pending bit |
| pend_sgi | output | 4 | Interrupt number to set pending |
| done | output | 1 | End-of-request pulse |
| done_any | output | 1 | At least one core was updated (valid with done) |

## Verification
The assertions check several properties on every cycle. Pulses appear only while a walk is running and are strictly ascending within a request. A broadcast never targets the requester. `done` lasts one cycle and clears `busy`, and `busy` only rises after a request strobe. The bench scenarios cover what a single property cannot show. They check the exact set of cores hit against a reference computed from the affinity table, the visit count implied by early termination, the `done_any` value, and that a strobe during a walk leaves no trace. The sweeps run broadcast from every requester and interrupt number, and targeted lists across two clusters and mismatched upper affinity levels.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int LIST_W = 16;
  localparam int AFF_W  = 8;
  localparam int SGI_W  = 4;
  localparam int ENT_W  = 4 * AFF_W;

  localparam int LIST_LSB = 0;
  localparam int AFF1_LSB = 16;
  localparam int SGI_LSB  = 24;
  localparam int AFF2_LSB = 32;
  localparam int MODE_BIT = 40;
  localparam int AFF3_LSB = 48;

  typedef struct packed {
    logic [SGI_W-1:0]  sgi;
    logic              bcast;
    logic [LIST_W-1:0] tlist;
    logic [AFF_W-1:0]  aff1;
    logic [AFF_W-1:0]  aff2;
    logic [AFF_W-1:0]  aff3;
  } sgi_req_t;
endpackage

// File: rtl/sgi_req_decode.sv
module sgi_req_decode
  import sgi_pkg::*;
(
  input  logic [63:0] word,
  output sgi_req_t    req
);
  logic unused_bits;

  always_comb begin
    req.tlist = word[LIST_LSB +: LIST_W];
    req.aff1  = word[AFF1_LSB +: AFF_W];
    req.sgi   = word[SGI_LSB +: SGI_W];
    req.aff2  = word[AFF2_LSB +: AFF_W];
    req.bcast = word[MODE_BIT];
    req.aff3  = word[AFF3_LSB +: AFF_W];
  end

  assign unused_bits = ^{word[63:56], word[47:41], word[31:28]};
endmodule

// File: rtl/sgi_core_match.sv
module sgi_core_match
  import sgi_pkg::*;
(
  input  sgi_req_t          req,
  input  logic [LIST_W-1:0] work_list,
  input  logic [ENT_W-1:0]  entry,
  output logic              hit,
  output logic [LIST_W-1:0] clr_bit
);
  localparam int L0_IDX_W = $clog2(LIST_W);

  logic [AFF_W-1:0] e_aff0, e_aff1, e_aff2, e_aff3;
  logic             upper_eq, l0_in_range, listed;

  always_comb begin
    e_aff0 = entry[0*AFF_W +: AFF_W];
    e_aff1 = entry[1*AFF_W +: AFF_W];
    e_aff2 = entry[2*AFF_W +: AFF_W];
    e_aff3 = entry[3*AFF_W +: AFF_W];
    upper_eq    = (e_aff1 == req.aff1) && (e_aff2 == req.aff2) &&
                  (e_aff3 == req.aff3);
    l0_in_range = (e_aff0 < AFF_W'(LIST_W));
    listed      = l0_in_range && work_list[e_aff0[L0_IDX_W-1:0]];
    hit         = upper_eq && listed;
    clr_bit     = '0;
    if (hit) clr_bit[e_aff0[L0_IDX_W-1:0]] = 1'b1;
  end
endmodule

// File: rtl/sgi_scan_ctrl.sv
module sgi_scan_ctrl
  import sgi_pkg::*;
#(
  parameter int NUM_CORES = 8,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  sgi_req_t          req_in,
  input  logic [IDX_W-1:0]  req_core,
  input  logic              tgt_hit,
  input  logic [LIST_W-1:0] tgt_clr,
  output sgi_req_t          req_q,
  output logic [LIST_W-1:0] work_list_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic              busy_q,
  output logic              pend_valid_q,
  output logic [IDX_W-1:0]  pend_core_q,
  output logic [SGI_W-1:0]  pend_sgi_q,
  output logic              done_q,
  output logic              done_any_q
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CORES - 1);

  logic [IDX_W-1:0]  reqc_q;
  logic              any_q;

  logic              start, visit, is_hit, last, finish;
  logic [LIST_W-1:0] list_nxt;
  logic              busy_d, any_d, done_d, done_any_d, pend_valid_d;
  logic [IDX_W-1:0]  idx_d;

  always_comb begin
    start    = req_valid && !busy_q;
    visit    = busy_q;
    is_hit   = req_q.bcast ? (idx_q != reqc_q) : tgt_hit;
    list_nxt = req_q.bcast ? work_list_q : (work_list_q & ~tgt_clr);
    last     = (idx_q == LAST_IDX);
    finish   = visit && (last || (!req_q.bcast && (list_nxt == '0)));

    busy_d = busy_q;
    if (start)       busy_d = 1'b1;
    else if (finish) busy_d = 1'b0;

    idx_d = idx_q;
    if (start)      idx_d = '0;
    else if (visit) idx_d = idx_q + 1'b1;

    any_d = any_q;
    if (start)                 any_d = 1'b0;
    else if (visit && is_hit)  any_d = 1'b1;

    pend_valid_d = visit && is_hit;
    done_d       = finish;
    done_any_d   = finish && (any_q || is_hit);
  end

  // request capture, enabled by start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      reqc_q <= '0;
    end else if (start) begin
      req_q  <= req_in;
      reqc_q <= req_core;
    end
  end

  // working list: loaded on start, shrinks on each visit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      work_list_q <= '0;
    else if (start)  work_list_q <= req_in.tlist;
    else if (visit)  work_list_q <= list_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      any_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      any_q  <= any_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid_q <= 1'b0;
      done_q       <= 1'b0;
      done_any_q   <= 1'b0;
    end else begin
      pend_valid_q <= pend_valid_d;
      done_q       <= done_d;
      done_any_q   <= done_any_d;
    end
  end

  // pulse payload, enabled only when a pulse is produced
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_core_q <= '0;
      pend_sgi_q  <= '0;
    end else if (pend_valid_d) begin
      pend_core_q <= idx_q;
      pend_sgi_q  <= req_q.sgi;
    end
  end

  a_r2_accept_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(req_valid));

  a_r5_pulse_only_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid_q |-> $past(busy_q));

  a_r5_ascending_order: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid_q && $past(pend_valid_q)) |-> (pend_core_q > $past(pend_core_q)));

  a_r3_skip_requester: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid_q && req_q.bcast) |-> (pend_core_q != reqc_q));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  a_r8_busy_falls_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  a_r8_any_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_any_q |-> done_q);
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int NUM_CORES = 8,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [63:0]            req_word,
  input  logic [IDX_W-1:0]       req_core,
  input  logic [NUM_CORES*32-1:0] core_aff_tbl,
  output logic                   busy,
  output logic                   pend_valid,
  output logic [IDX_W-1:0]       pend_core,
  output logic [3:0]             pend_sgi,
  output logic                   done,
  output logic                   done_any
);
  sgi_req_t          req_dec, req_q;
  logic [LIST_W-1:0] work_list_q, tgt_clr;
  logic [IDX_W-1:0]  idx_q;
  logic              tgt_hit;
  logic [ENT_W-1:0]  aff_ent [NUM_CORES];
  logic [ENT_W-1:0]  cur_ent;

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_tbl
    assign aff_ent[g] = core_aff_tbl[g*ENT_W +: ENT_W];
  end

  always_comb begin
    cur_ent = '0;
    for (int i = 0; i < NUM_CORES; i++)
      if (idx_q == IDX_W'(i)) cur_ent = aff_ent[i];
  end

  sgi_req_decode u_dec (
    .word (req_word),
    .req  (req_dec)
  );

  sgi_core_match u_match (
    .req       (req_q),
    .work_list (work_list_q),
    .entry     (cur_ent),
    .hit       (tgt_hit),
    .clr_bit   (tgt_clr)
  );

  sgi_scan_ctrl #(.NUM_CORES(NUM_CORES)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_in       (req_dec),
    .req_core     (req_core),
    .tgt_hit      (tgt_hit),
    .tgt_clr      (tgt_clr),
    .req_q        (req_q),
    .work_list_q  (work_list_q),
    .idx_q        (idx_q),
    .busy_q       (busy),
    .pend_valid_q (pend_valid),
    .pend_core_q  (pend_core),
    .pend_sgi_q   (pend_sgi),
    .done_q       (done),
    .done_any_q   (done_any)
  );
endmodule

// File: tb/sgi_dispatch_tb_top.sv
`timescale 1ns/1ps
module sgi_dispatch_tb_top;
  localparam int N = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [63:0]   req_word = '0;
  logic [IW-1:0] req_core = '0;
  logic [N*32-1:0] core_aff_tbl;
  logic          busy, pend_valid, done, done_any;
  logic [IW-1:0] pend_core;
  logic [3:0]    pend_sgi;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sgi_dispatch #(.NUM_CORES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
    .req_core(req_core), .core_aff_tbl(core_aff_tbl), .busy(busy),
    .pend_valid(pend_valid), .pend_core(pend_core), .pend_sgi(pend_sgi),
    .done(done), .done_any(done_any)
  );

  // bench affinity table: cluster = i/4; level 0 = i%4 except core 6 (17) and core 7 (5)
  function automatic int l0_of(int i);
    if (i == 6) return 17;
    if (i == 7) return 5;
    return i % 4;
  endfunction

  initial begin
    for (int i = 0; i < N; i++)
      core_aff_tbl[i*32 +: 32] = {8'd0, 8'd0, 8'(i / 4), 8'(l0_of(i))};
  end

  function automatic logic [63:0] mk(int sgi, bit bc, int list, int a1, int a2, int a3);
    logic [63:0] w;
    w = '0;
    w[15:0]  = 16'(list);
    w[23:16] = 8'(a1);
    w[27:24] = 4'(sgi);
    w[39:32] = 8'(a2);
    w[40]    = bc;
    w[55:48] = 8'(a3);
    return w;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // run one request; intrude=1 drives a second strobe during the walk
  task automatic run(int sgi, bit bc, int list, int a1, int a2, int a3, int rq, bit intrude);
    int exp_mask, exp_cyc, m, got_mask, cyc, last_core;
    bit sgi_ok, order_ok, busy_ok, got_any;
    exp_mask = 0; exp_cyc = N; m = list;
    if (bc) begin
      for (int i = 0; i < N; i++) if (i != rq) exp_mask |= (1 << i);
    end else begin
      for (int i = 0; i < N; i++) begin
        int l0;
        l0 = l0_of(i);
        if (a1 == i / 4 && a2 == 0 && a3 == 0 && l0 < 16 && m[l0]) begin
          exp_mask |= (1 << i);
          m &= ~(1 << l0);
        end
        if (m == 0) begin exp_cyc = i + 1; break; end
      end
    end
    @(negedge clk);
    req_word = mk(sgi, bc, list, a1, a2, a3);
    req_core = IW'(rq);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    got_mask = 0; cyc = 0; last_core = -1;
    sgi_ok = 1; order_ok = 1; busy_ok = 1; got_any = 0;
    while (1) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (intrude && cyc == 1) begin
        req_word = mk(15, 1'b1, 16'hFFFF, 0, 0, 0);
        req_core = 0;
        req_valid = 1'b1;
      end else if (intrude) req_valid = 1'b0;
      if (pend_valid) begin
        got_mask |= (1 << pend_core);
        got_any = 1;
        if (int'(pend_sgi) != sgi) sgi_ok = 0;
        if (int'(pend_core) <= last_core) order_ok = 0;
        last_core = int'(pend_core);
      end
      if (done) break;
      if (!busy) busy_ok = 0;
      if (cyc > 40) begin chk(0, "watchdog", cyc, exp_cyc); break; end
    end
    req_valid = 1'b0;
    chk(got_mask == exp_mask, bc ? "R3 broadcast hit set" : "R4 targeted hit set", got_mask, exp_mask);
    chk(cyc == exp_cyc, bc ? "R3 walk length" : "R6/R7 walk length", cyc, exp_cyc);
    chk(done_any == (exp_mask != 0), "R8 done_any", done_any, exp_mask != 0);
    chk(!busy && busy_ok, "R8 busy over walk", busy, 0);
    if (got_any) begin
      chk(sgi_ok, "R1 pend_sgi number", pend_sgi, sgi);
      chk(order_ok, "R5 ascending single pulses", last_core, 0);
    end
    if (intrude) begin
      bit quiet;
      quiet = 1;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (busy || pend_valid || done) quiet = 0;
      end
      chk(quiet, "R2 strobe during walk ignored", busy, 0);
    end
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !pend_valid && !done && !done_any, "R9 reset idle", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !pend_valid && !done, "R9 idle after release", busy, 0);
    // R3, R1: broadcast from every requester, every interrupt number
    for (int s = 0; s < 16; s++) run(s, 1'b1, s * 4099, s % 3, 0, 0, s % N, 1'b0);
    // R4, R6, R7: targeted sweep over two clusters and low list bits
    for (int a1 = 0; a1 < 2; a1++)
      for (int l = 0; l < 64; l++) run(l % 16, 1'b0, l, a1, 0, 0, l % N, 1'b0);
    // R4: full list, bit for level 17 cannot exist, core 7 at level 5
    run(3, 1'b0, 16'hFFFF, 0, 0, 0, 1, 1'b0);
    run(4, 1'b0, 16'h0021, 1, 0, 0, 2, 1'b0);
    run(5, 1'b0, 16'h0002, 1, 0, 0, 2, 1'b0);
    // R7: upper-level mismatches hit nothing and walk all cores
    run(6, 1'b0, 16'hFFFF, 0, 1, 0, 0, 1'b0);
    run(7, 1'b0, 16'hFFFF, 0, 0, 1, 0, 1'b0);
    run(8, 1'b0, 16'h000F, 2, 0, 0, 0, 1'b0);
    // R2: strobe during walk
    run(9, 1'b0, 16'h0009, 0, 0, 0, 4, 1'b1);
    run(10, 1'b1, 0, 0, 0, 0, 3, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule